// File: doc/BRIEF.md
# Programmable chip select decoder

This block decodes each bus cycle against a bank of eight programmable chip-select channels. Every channel holds a configuration word and a mask word, both writable and readable through a small register port. The configuration word gives a base address, a memory interface mode, a data width, a privilege restriction, an optional transfer-type and modifier qualifier, and a channel enable. The mask word lets software widen the window the channel covers by removing selected address bits from the compare.

The bus-cycle inputs are registered once. From that registered cycle the block drives one active-low chip select, or flags an access error when the channel that claims the cycle is restricted to supervisor accesses and the cycle comes from user mode. For the selected channel it also presents the interface mode and data width, so that the downstream bus controller can pick its timing and sizing. Channel 0 comes out of reset enabled at address zero, with its width taken from two strap pins, so that boot fetches reach the boot device before any software runs.

Top module: `cs_decoder`

## Requirements
- R1: After reset, channel 0 reads 0x0000_0001 with bits 9–8 equal to the strap inputs. Channels 1 to 6 read 0x0000_n300 and channel 7 reads 0x0000_7700. Every mask word reads zero.
- R2: The configuration word of channel n sits at byte offset 0x040 + 8n and its mask word at 0x044 + 8n. A mask write keeps bits 31–12 and reads back with bits 11–0 zero. Reads of any other offset, including misaligned ones, return zero, and writes to them change nothing.
- R3: Configuration word fields: bit 0 enable, bit 1 attribute-compare enable, bits 4–2 transfer modifier, bits 6–5 transfer type, bit 7 supervisor-only, bits 9–8 width, bits 11–10 mode, bits 31–12 base. Address bits 31–12 must equal the base field, except where the mask word holds a 1 in the same bit position (bits 31–12).
- R4: A channel whose enable bit is 0 never asserts its chip select.
- R5: When supervisor-only is 1, the channel selects only supervisor cycles. A user cycle that the channel would otherwise claim raises the access error and asserts no chip select.
- R6: With the attribute-compare bit set, the cycle's transfer type and modifier must both equal the programmed fields. With it clear, both are ignored.
- R7: When several channels claim a cycle, only the lowest-numbered one is used, both for its chip select and for its privilege check.
- R8: Outputs follow the bus-cycle inputs sampled at the previous rising clock edge. With the sampled valid low, every chip select is high and the access error is low.
- R9: Mode (00 SRAM/ROM with byte strobes, 01 SDRAM, 10 reserved, 11 8-bit SRAM/ROM) and width (00 32-bit, 01 8-bit, 10 16-bit, 11 32-bit line) follow the selected channel. Both are zero when no chip select is asserted.
- R10: At most one chip select is low at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strap_bw_i | input | 2 | Channel 0 width loaded at reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 9 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from reg_addr_i |
| cyc_valid_i | input | 1 | Bus cycle present |
| cyc_addr_i | input | 32 | Bus cycle address |
| cyc_super_i | input | 1 | Cycle is supervisor mode |
| cyc_tt_i | input | 2 | Cycle transfer type |
| cyc_tm_i | input | 3 | Cycle transfer modifier |
| cs_no | output | 8 | Chip selects, active low |
| acc_err_o | output | 1 | Privilege access error |
| sel_mode_o | output | 2 | Interface mode of the selected channel |
| sel_width_o | output | 2 | Data width of the selected channel |

## Verification
A register write takes effect at the rising edge that samples it, and read data is combinational, so the bench writes on one falling edge and reads back on the next. A bus cycle driven on a falling edge is captured at the following rising edge, and the chip select, error, mode and width are due from then on. The bench samples them on the second falling edge after driving. The latency test also samples just after driving and just after the valid input is dropped, to show that the outputs lag the inputs by exactly one edge.

// File: rtl/cs_pkg.sv
package cs_pkg;
  localparam int BA_W = 20;

  typedef enum logic [1:0] {
    MODE_SRAM_BS = 2'b00,
    MODE_SDRAM   = 2'b01,
    MODE_RSVD    = 2'b10,
    MODE_SRAM8   = 2'b11
  } if_mode_e;

  typedef enum logic [1:0] {
    WID_32   = 2'b00,
    WID_8    = 2'b01,
    WID_16   = 2'b10,
    WID_LINE = 2'b11
  } bus_wid_e;

  typedef struct packed {
    logic [BA_W-1:0] ba;
    if_mode_e        mode;
    bus_wid_e        wid;
    logic            sup;
    logic [1:0]      tt;
    logic [2:0]      tm;
    logic            ctm;
    logic            en;
  } chan_cfg_t;

  function automatic chan_cfg_t rst_cfg(input int ch, input logic [1:0] strap, input int num_ch);
    chan_cfg_t r;
    r    = '0;
    r.ba = BA_W'(ch);
    if (ch == 0) begin
      r.wid = bus_wid_e'(strap);
      r.en  = 1'b1;
    end else begin
      r.wid  = WID_LINE;
      r.mode = (ch == num_ch - 1) ? MODE_SDRAM : MODE_SRAM_BS;
    end
    return r;
  endfunction
endpackage

// File: rtl/cs_regfile.sv
module cs_regfile
  import cs_pkg::*;
#(
  parameter int NUM_CH   = 8,
  parameter int REG_AW   = 9,
  parameter int REG_BASE = 'h40
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [1:0]                   strap_bw_i,
  input  logic                         we_i,
  input  logic [REG_AW-1:0]            addr_i,
  input  logic [31:0]                  wdata_i,
  output logic [31:0]                  rdata_o,
  output chan_cfg_t [NUM_CH-1:0]       cfg_o,
  output logic [NUM_CH-1:0][BA_W-1:0]  mask_o
);
  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam logic [REG_AW:0] LO_A = (REG_AW+1)'(REG_BASE);
  localparam logic [REG_AW:0] HI_A = (REG_AW+1)'(REG_BASE + 8 * NUM_CH);

  chan_cfg_t [NUM_CH-1:0]      cfg_q;
  logic [NUM_CH-1:0][BA_W-1:0] mask_q;
  logic                        in_rng;
  logic [REG_AW-1:0]           off;
  logic [IDX_W-1:0]            idx;
  logic                        is_mask;

  always_comb begin
    in_rng  = ({1'b0, addr_i} >= LO_A) && ({1'b0, addr_i} < HI_A) && (addr_i[1:0] == 2'b00);
    off     = addr_i - REG_AW'(REG_BASE);
    idx     = off[3 +: IDX_W];
    is_mask = off[2];
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cfg_q[c]  <= rst_cfg(c, strap_bw_i, NUM_CH);
        mask_q[c] <= '0;
      end else if (we_i && in_rng && idx == IDX_W'(c)) begin
        if (is_mask) mask_q[c] <= wdata_i[31 -: BA_W];
        else         cfg_q[c]  <= chan_cfg_t'(wdata_i);
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (in_rng) rdata_o = is_mask ? {mask_q[idx], {(32-BA_W){1'b0}}} : 32'(cfg_q[idx]);
  end

  assign cfg_o  = cfg_q;
  assign mask_o = mask_q;

  // R2
  reg_wr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && in_rng) |=> $stable(cfg_q) && $stable(mask_q));
endmodule

// File: rtl/cs_chan_match.sv
module cs_chan_match
  import cs_pkg::*;
(
  input  chan_cfg_t       cfg_i,
  input  logic [BA_W-1:0] mask_i,
  input  logic [BA_W-1:0] addr_hi_i,
  input  logic            super_i,
  input  logic [1:0]      tt_i,
  input  logic [2:0]      tm_i,
  output logic            claim_o,
  output logic            priv_o
);
  logic addr_eq;
  logic attr_ok;

  always_comb begin
    addr_eq = (((addr_hi_i ^ cfg_i.ba) & ~mask_i) == '0);
    attr_ok = !cfg_i.ctm || ((tt_i == cfg_i.tt) && (tm_i == cfg_i.tm));
    claim_o = cfg_i.en && addr_eq && attr_ok;
    // claimed but privilege forbids the select
    priv_o  = cfg_i.sup && !super_i;
  end
endmodule

// File: rtl/cs_lowest_pick.sv
module cs_lowest_pick #(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic [N-1:0]  gnt_o,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  always_comb begin
    gnt_o = '0;
    idx_o = '0;
    any_o = |req_i;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        gnt_o = '0;
        gnt_o[i] = 1'b1;
        idx_o = IW'(i);
      end
    end
  end
endmodule

// File: rtl/cs_decoder.sv
module cs_decoder
  import cs_pkg::*;
#(
  parameter int NUM_CH   = 8,
  parameter int REG_AW   = 9,
  parameter int REG_BASE = 'h40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        strap_bw_i,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              cyc_valid_i,
  input  logic [31:0]       cyc_addr_i,
  input  logic              cyc_super_i,
  input  logic [1:0]        cyc_tt_i,
  input  logic [2:0]        cyc_tm_i,
  output logic [NUM_CH-1:0] cs_no,
  output logic              acc_err_o,
  output logic [1:0]        sel_mode_o,
  output logic [1:0]        sel_width_o
);
  localparam int IW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  chan_cfg_t [NUM_CH-1:0]      cfg;
  logic [NUM_CH-1:0][BA_W-1:0] mask;

  logic            valid_q;
  logic [BA_W-1:0] addr_q;
  logic            super_q;
  logic [1:0]      tt_q;
  logic [2:0]      tm_q;

  logic [NUM_CH-1:0] claim;
  logic [NUM_CH-1:0] priv;
  logic [NUM_CH-1:0] gnt;
  logic [IW-1:0]     win;
  logic              any;
  logic              sel_ok;

  cs_regfile #(.NUM_CH(NUM_CH), .REG_AW(REG_AW), .REG_BASE(REG_BASE)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .strap_bw_i(strap_bw_i),
    .we_i      (reg_we_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .rdata_o   (reg_rdata_o),
    .cfg_o     (cfg),
    .mask_o    (mask)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      super_q <= 1'b0;
      tt_q    <= '0;
      tm_q    <= '0;
    end else begin
      valid_q <= cyc_valid_i;
      addr_q  <= cyc_addr_i[31 -: BA_W];
      super_q <= cyc_super_i;
      tt_q    <= cyc_tt_i;
      tm_q    <= cyc_tm_i;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_match
    cs_chan_match u_match (
      .cfg_i    (cfg[c]),
      .mask_i   (mask[c]),
      .addr_hi_i(addr_q),
      .super_i  (super_q),
      .tt_i     (tt_q),
      .tm_i     (tm_q),
      .claim_o  (claim[c]),
      .priv_o   (priv[c])
    );
  end

  cs_lowest_pick #(.N(NUM_CH)) u_pick (
    .req_i(claim),
    .gnt_o(gnt),
    .idx_o(win),
    .any_o(any)
  );

  always_comb begin
    sel_ok      = valid_q && any && !priv[win];
    acc_err_o   = valid_q && any && priv[win];
    cs_no       = sel_ok ? ~gnt : '1;
    sel_mode_o  = sel_ok ? cfg[win].mode : 2'b00;
    sel_width_o = sel_ok ? cfg[win].wid  : 2'b00;
  end

  // R10
  cs_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_no));

  // R8
  cs_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cyc_valid_i |=> (&cs_no) && !acc_err_o);

  // R5
  err_no_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_err_o |-> (&cs_no));

  // R9
  sel_idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&cs_no) |-> (sel_mode_o == 2'b00) && (sel_width_o == 2'b00));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    // R4
    cs_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cs_no[c] |-> cfg[c].en);
    // R5
    cs_priv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!cs_no[c] && cfg[c].sup) |-> super_q);
  end
endmodule

// File: tb/sim_cs_decoder.sv
module sim_cs_decoder;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  strap_bw_i = 2'b10;
  logic        reg_we_i = 1'b0;
  logic [8:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        cyc_valid_i = 1'b0;
  logic [31:0] cyc_addr_i = '0;
  logic        cyc_super_i = 1'b0;
  logic [1:0]  cyc_tt_i = '0;
  logic [2:0]  cyc_tm_i = '0;
  logic [7:0]  cs_no;
  logic        acc_err_o;
  logic [1:0]  sel_mode_o;
  logic [1:0]  sel_width_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  cs_decoder u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, input logic [31:0] exp, input string req);
    @(negedge clk_i);
    reg_addr_i = a;
    #1 chk(req, reg_rdata_o, exp);
  endtask

  // result packed as {cs_no, err, mode, width}
  task automatic acc(input logic [31:0] a, input logic sup, input logic [1:0] tt, input logic [2:0] tm,
                     input logic [7:0] e_cs, input logic e_err, input logic [1:0] e_mode,
                     input logic [1:0] e_wid, input string req);
    @(negedge clk_i);
    cyc_valid_i = 1'b1; cyc_addr_i = a; cyc_super_i = sup; cyc_tt_i = tt; cyc_tm_i = tm;
    @(negedge clk_i);
    chk(req, 32'({cs_no, acc_err_o, sel_mode_o, sel_width_o}), 32'({e_cs, e_err, e_mode, e_wid}));
    cyc_valid_i = 1'b0;
  endtask

  task automatic t_reset;
    chk("R8 reset idle", 32'({cs_no, acc_err_o}), 32'({8'hFF, 1'b0}));
    rd(9'h040, 32'h0000_0201, "R1 ch0 reset");
    for (int c = 1; c < 7; c++) rd(9'(9'h040 + 8 * c), 32'h300 | 32'(c << 12), "R1 chn reset");
    rd(9'h078, 32'h0000_7700, "R1 ch7 reset");
    for (int c = 0; c < 8; c++) rd(9'(9'h044 + 8 * c), 32'h0, "R1 mask reset");
  endtask

  task automatic t_regs;
    wr(9'h058, 32'h3ABC_D300);
    rd(9'h058, 32'h3ABC_D300, "R2 cfg readback");
    wr(9'h05C, 32'hFFFF_FFFF);
    rd(9'h05C, 32'hFFFF_F000, "R2 mask readback");
    wr(9'h000, 32'hFFFF_FFFF);
    wr(9'h05A, 32'h0000_0000);
    rd(9'h000, 32'h0, "R2 unmapped read");
    rd(9'h080, 32'h0, "R2 past end read");
    rd(9'h05A, 32'h0, "R2 misaligned read");
    rd(9'h058, 32'h3ABC_D300, "R2 stray write ignored");
  endtask

  task automatic t_enable;
    acc(32'h3ABC_D000, 1'b1, 2'd0, 3'd0, 8'hFF, 1'b0, 2'b00, 2'b00, "R4 disabled ch3 full mask");
    acc(32'h0000_1004, 1'b1, 2'd0, 3'd0, 8'hFF, 1'b0, 2'b00, 2'b00, "R4 disabled ch1");
    wr(9'h048, 32'h0000_1301);
    acc(32'h0000_1004, 1'b1, 2'd0, 3'd0, 8'hFD, 1'b0, 2'b00, 2'b11, "R4 enabled ch1");
  endtask

  task automatic t_boot;
    acc(32'h0000_0100, 1'b1, 2'd0, 3'd0, 8'hFE, 1'b0, 2'b00, 2'b10, "R9 boot ch0 strap width");
    acc(32'h0000_0FFC, 1'b0, 2'd3, 3'd7, 8'hFE, 1'b0, 2'b00, 2'b10, "R6 ch0 user attrs ignored");
  endtask

  task automatic t_mask;
    wr(9'h050, 32'h2000_0301);
    wr(9'h054, 32'h000F_F000);
    acc(32'h200F_F123, 1'b1, 2'd0, 3'd0, 8'hFB, 1'b0, 2'b00, 2'b11, "R3 masked bits differ");
    acc(32'h2000_0ABC, 1'b1, 2'd0, 3'd0, 8'hFB, 1'b0, 2'b00, 2'b11, "R3 exact base");
    acc(32'h2010_0000, 1'b1, 2'd0, 3'd0, 8'hFF, 1'b0, 2'b00, 2'b00, "R3 unmasked bit differs");
  endtask

  task automatic t_super;
    wr(9'h060, 32'h0000_4381);
    acc(32'h0000_4010, 1'b0, 2'd0, 3'd0, 8'hFF, 1'b1, 2'b00, 2'b00, "R5 user on super region");
    acc(32'h0000_4010, 1'b1, 2'd0, 3'd0, 8'hEF, 1'b0, 2'b00, 2'b11, "R5 super on super region");
  endtask

  task automatic t_ctm;
    wr(9'h068, 32'h0000_5357);
    acc(32'h0000_5000, 1'b1, 2'd2, 3'd5, 8'hDF, 1'b0, 2'b00, 2'b11, "R6 attrs match");
    acc(32'h0000_5000, 1'b1, 2'd1, 3'd5, 8'hFF, 1'b0, 2'b00, 2'b00, "R6 tt mismatch");
    acc(32'h0000_5000, 1'b1, 2'd2, 3'd4, 8'hFF, 1'b0, 2'b00, 2'b00, "R6 tm mismatch");
    wr(9'h068, 32'h0000_5355);
    acc(32'h0000_5000, 1'b1, 2'd1, 3'd0, 8'hDF, 1'b0, 2'b00, 2'b11, "R6 compare off");
  endtask

  task automatic t_prio;
    wr(9'h070, 32'h0000_6301);
    wr(9'h078, 32'h0000_7701);
    wr(9'h07C, 32'hFFFF_F000);
    acc(32'h0000_6000, 1'b1, 2'd0, 3'd0, 8'hBF, 1'b0, 2'b00, 2'b11, "R7 ch6 over ch7");
    acc(32'h0000_9000, 1'b1, 2'd0, 3'd0, 8'h7F, 1'b0, 2'b01, 2'b11, "R7 R9 ch7 catch-all sdram");
    acc(32'h0000_0100, 1'b1, 2'd0, 3'd0, 8'hFE, 1'b0, 2'b00, 2'b10, "R7 ch0 over ch7");
    acc(32'h0000_4000, 1'b0, 2'd0, 3'd0, 8'hFF, 1'b1, 2'b00, 2'b00, "R7 R5 lower super wins");
  endtask

  task automatic t_latency;
    @(negedge clk_i);
    cyc_valid_i = 1'b1; cyc_addr_i = 32'h0000_0200; cyc_super_i = 1'b1;
    #1 chk("R8 not before edge", 32'(cs_no), 32'hFF);
    @(negedge clk_i);
    chk("R8 after one edge", 32'(cs_no), 32'hFE);
    cyc_valid_i = 1'b0;
    #1 chk("R8 held until edge", 32'(cs_no), 32'hFE);
    @(negedge clk_i);
    chk("R8 idle after drop", 32'({cs_no, acc_err_o}), 32'({8'hFF, 1'b0}));
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_regs();
    t_enable();
    t_boot();
    t_mask();
    t_super();
    t_ctm();
    t_prio();
    t_latency();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog act=hung exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule